// File: doc/BRIEF.md
# Boot image record sector scanner

This block searches a flash array for a bootable image. It starts at sector 0 and, at the base of each 32 KB sector, reads a 16-byte image record one byte at a time through a simple request/response byte port. A record is accepted when three checks pass. Its leading 12 bytes must match an accepted signature. Its status byte must be neither the erased value nor the invalidated value. Its two-byte application identifier must equal a search value supplied on an input. The first accepted record ends the search, so the lowest qualifying sector always wins.

When a record carries a good signature but is not taken, the scan skips ahead by the image length written in that record. When the signature is wrong, the scan moves one sector. If the internal sectors are used up, the same walk is repeated on the external memory when that is enabled. Otherwise the block reports a fallback: enter the serial programming mode, or halt if that mode is disabled. The result is presented with a one-cycle completion strobe and held until the next start.

Top module: `bir_sector_scan`

## Requirements
- R1: While reset is held low at a clock edge, and after it until a start, busy, done, found, rd_req and found_ext are 0 and action is 0 (none).
- R2: For a sector s, the record bytes are read at rd_addr = s*32768 + k for k = 0..15 in increasing k, with one request outstanding at a time. Bytes 0..11 are the signature, most significant byte first. Byte 12 is the configuration, byte 13 the status, and bytes 14 and 15 the application identifier, high byte first.
- R3: Signature bytes 12 34 56 78 11 22 33 44 55 66 77 88 are always accepted. Bytes 12 34 56 78 22 33 44 55 66 77 88 99 are accepted only while alt_magic_en is 1. Any other signature is rejected.
- R4: A status byte of 0x00 or 0xFF rejects the record. Every other value (0x01 to 0xFE) passes.
- R5: A record passes only when its identifier {byte14, byte15} equals search_id.
- R6: The first sector whose record passes all checks ends the scan. No record is read after it, and found_sector reports that sector.
- R7: If the signature is accepted but the record is rejected, the next sector examined is s + cfg[7:4] + 1. A step that reaches or passes NUM_SECTORS ends the walk of that memory.
- R8: If the signature is rejected, the next sector examined is s + 1.
- R9: When the internal walk ends without a hit and ext_enable is 1, the walk restarts at sector 0 with rd_ext = 1. A hit there reports found_ext = 1.
- R10: When no memory yields a hit, found is 0 and action is 2 (programming) if prog_enable is 1, otherwise 3 (halt).
- R11: done is high for exactly one cycle per scan. found, found_ext, found_sector, found_size and action then hold until the next accepted start. A start while busy is ignored.
- R12: On a hit, action is 1 (boot) and found_size equals cfg[7:4] of the chosen record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a scan (taken only when idle) |
| search_id | input | 16 | Application identifier to look for |
| alt_magic_en | input | 1 | Also accept the second signature |
| ext_enable | input | 1 | Search external memory after internal |
| prog_enable | input | 1 | Fallback to programming mode rather than halt |
| rd_req | output | 1 | One-cycle byte read request |
| rd_ext | output | 1 | Request targets external memory |
| rd_addr | output | SEC_W+SECTOR_OFF_W | Byte address of the read |
| rd_valid | input | 1 | Read data is present |
| rd_data | input | 8 | Read data byte |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle completion strobe |
| found | output | 1 | A record was selected |
| found_ext | output | 1 | The selected record is in external memory |
| found_sector | output | SEC_W | Sector of the selected record |
| found_size | output | 4 | Image size code of the selected record |
| action | output | 2 | 0 none, 1 boot, 2 programming, 3 halt |

## Verification
A single record is placed at sector 2 and varied in one field at a time: each signature, alt enable on and off, a corrupted signature, status 0x00, 0xFF and a reserved value, and an identifier that matches only in the correct byte order. These cases separate the three acceptance checks, and the count of bytes read shows whether a miss advanced by one sector. Layouts with a rejected good-signature record in front, two qualifying records, an external-only image, and an oversized size code at the last sector show size-based stepping, lowest-sector priority, the external retry, and the end-of-array cutoff. The programming and halt outcomes are told apart by prog_enable and ext_enable.

// File: rtl/bir_scan_pkg.sv
package bir_scan_pkg;
    // Record layout: byte positions inside the 16-byte image record
    localparam logic [3:0] MAGIC_LAST = 4'd11;
    localparam logic [3:0] IDX_CFG    = 4'd12;
    localparam logic [3:0] IDX_STAT   = 4'd13;
    localparam logic [3:0] IDX_IDH    = 4'd14;
    localparam logic [3:0] IDX_IDL    = 4'd15;

    localparam int NUM_PATTERNS = 2;
    localparam logic [95:0] SIG_PRIMARY = 96'h123456781122334455667788;
    localparam logic [95:0] SIG_SECOND  = 96'h123456782233445566778899;

    typedef enum logic [1:0] {
        ACT_NONE = 2'd0,
        ACT_BOOT = 2'd1,
        ACT_PROG = 2'd2,
        ACT_HALT = 2'd3
    } boot_act_e;

    // Byte idx of a 96-bit signature, most significant byte first
    function automatic logic [7:0] sig_byte(input logic [95:0] pat, input logic [3:0] idx);
        int sh;
        sh = 88 - 8 * int'(idx);
        return pat[sh +: 8];
    endfunction
endpackage

// File: rtl/bir_rec_check.sv
// Record checker: folds the record bytes into pass/fail flags as they arrive.
// Assumes bytes come in index order, starting at index 0 for each record.
module bir_rec_check
    import bir_scan_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cap,
    input  logic [3:0]  idx,
    input  logic [7:0]  data,
    input  logic [15:0] search_id,
    input  logic        alt_en,
    output logic        magic_ok,
    output logic        accept,
    output logic [3:0]  size_code
);
    logic [NUM_PATTERNS-1:0] pat_hit;
    logic [3:0]  cfg_hi_q;
    logic [7:0]  stat_q;
    logic [15:0] id_q;

    for (genvar p = 0; p < NUM_PATTERNS; p++) begin : g_pat
        localparam logic [95:0] PAT = (p == 0) ? SIG_PRIMARY : SIG_SECOND;
        logic hit_q;
        // Running match of the signature bytes against one pattern
        always_ff @(posedge clk) begin
            if (!rst_n)
                hit_q <= 1'b0;
            else if (cap && idx <= MAGIC_LAST)
                hit_q <= ((idx == 4'd0) ? 1'b1 : hit_q) && (data == sig_byte(PAT, idx));
        end
        assign pat_hit[p] = hit_q;
    end

    // Capture of the configuration, status and identifier bytes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_hi_q <= '0;
            stat_q   <= '0;
            id_q     <= '0;
        end else if (cap) begin
            if (idx == IDX_CFG)  cfg_hi_q   <= data[7:4];
            if (idx == IDX_STAT) stat_q     <= data;
            if (idx == IDX_IDH)  id_q[15:8] <= data;
            if (idx == IDX_IDL)  id_q[7:0]  <= data;
        end
    end

    // Combined verdict for the record just read
    always_comb begin
        magic_ok  = pat_hit[0] | (alt_en & pat_hit[1]);
        accept    = magic_ok && (stat_q != 8'h00) && (stat_q != 8'hFF) && (id_q == search_id);
        size_code = cfg_hi_q;
    end
endmodule

// File: rtl/bir_step.sv
// Step calculator: next sector to examine and whether the array is used up.
// Assumes size_code is only meaningful when magic_ok is set.
module bir_step #(
    parameter int NUM_SECTORS = 16,
    parameter int SEC_W       = 4
) (
    input  logic [SEC_W-1:0] cur,
    input  logic             magic_ok,
    input  logic [3:0]       size_code,
    output logic [SEC_W-1:0] nxt,
    output logic             past_end
);
    localparam int NXT_W = SEC_W + 5;

    logic [4:0]       step;
    logic [NXT_W-1:0] wide;

    // Advance by the record's own length or by a single sector
    always_comb begin
        step     = magic_ok ? ({1'b0, size_code} + 5'd1) : 5'd1;
        wide     = {5'b0, cur} + {{SEC_W{1'b0}}, step};
        past_end = wide >= NXT_W'(NUM_SECTORS);
        nxt      = wide[SEC_W-1:0];
    end
endmodule

// File: rtl/bir_sector_scan.sv
// Sector scanner: walks internal, then optionally external, flash for the first
// acceptable image record and reports it or a fallback action.
// Assumes the byte port answers each one-cycle request with rd_valid later,
// and that the configuration inputs stay constant during a scan.
module bir_sector_scan
    import bir_scan_pkg::*;
#(
    parameter int NUM_SECTORS  = 16,
    parameter int SECTOR_OFF_W = 15,
    localparam int SEC_W  = (NUM_SECTORS > 1) ? $clog2(NUM_SECTORS) : 1,
    localparam int ADDR_W = SEC_W + SECTOR_OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [15:0]       search_id,
    input  logic              alt_magic_en,
    input  logic              ext_enable,
    input  logic              prog_enable,
    output logic              rd_req,
    output logic              rd_ext,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_valid,
    input  logic [7:0]        rd_data,
    output logic              busy,
    output logic              done,
    output logic              found,
    output logic              found_ext,
    output logic [SEC_W-1:0]  found_sector,
    output logic [3:0]        found_size,
    output logic [1:0]        action
);
    typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT, S_EVAL} scan_st_e;

    scan_st_e         state;
    logic [SEC_W-1:0] sec_q;
    logic             ext_q;
    logic [3:0]       byte_q;

    logic             magic_ok, accept;
    logic [3:0]       size_code;
    logic [SEC_W-1:0] nxt_sec;
    logic             past_end;
    logic             go, retry_ext, fin_hit, fin_miss;

    bir_rec_check u_check (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap       (state == S_WAIT && rd_valid),
        .idx       (byte_q),
        .data      (rd_data),
        .search_id (search_id),
        .alt_en    (alt_magic_en),
        .magic_ok  (magic_ok),
        .accept    (accept),
        .size_code (size_code)
    );

    bir_step #(.NUM_SECTORS(NUM_SECTORS), .SEC_W(SEC_W)) u_step (
        .cur       (sec_q),
        .magic_ok  (magic_ok),
        .size_code (size_code),
        .nxt       (nxt_sec),
        .past_end  (past_end)
    );

    // Decode of start acceptance and end-of-record outcomes
    always_comb begin
        go        = (state == S_IDLE) && start;
        retry_ext = !ext_q && ext_enable;
        fin_hit   = (state == S_EVAL) && accept;
        fin_miss  = (state == S_EVAL) && !accept && past_end && !retry_ext;
    end

    // Sequencer: byte fetches per record, then step, switch memory or finish
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            sec_q  <= '0;
            ext_q  <= 1'b0;
            byte_q <= '0;
        end else begin
            case (state)
                S_IDLE: if (go) begin
                    sec_q  <= '0;
                    ext_q  <= 1'b0;
                    byte_q <= '0;
                    state  <= S_REQ;
                end
                S_REQ:  state <= S_WAIT;
                S_WAIT: if (rd_valid) begin
                    if (byte_q == IDX_IDL) begin
                        state <= S_EVAL;
                    end else begin
                        byte_q <= byte_q + 4'd1;
                        state  <= S_REQ;
                    end
                end
                S_EVAL: begin
                    byte_q <= '0;
                    if (fin_hit || fin_miss) begin
                        state <= S_IDLE;
                    end else if (!past_end) begin
                        sec_q <= nxt_sec;
                        state <= S_REQ;
                    end else begin
                        ext_q <= 1'b1;
                        sec_q <= '0;
                        state <= S_REQ;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // Result registers: cleared on start, loaded once at the end of a scan
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done         <= 1'b0;
            found        <= 1'b0;
            found_ext    <= 1'b0;
            found_sector <= '0;
            found_size   <= '0;
            action       <= ACT_NONE;
        end else begin
            done <= fin_hit || fin_miss;
            if (go) begin
                found        <= 1'b0;
                found_ext    <= 1'b0;
                found_sector <= '0;
                found_size   <= '0;
                action       <= ACT_NONE;
            end else if (fin_hit) begin
                found        <= 1'b1;
                found_ext    <= ext_q;
                found_sector <= sec_q;
                found_size   <= size_code;
                action       <= ACT_BOOT;
            end else if (fin_miss) begin
                action <= prog_enable ? ACT_PROG : ACT_HALT;
            end
        end
    end

    // Byte port drive and status
    always_comb begin
        rd_req  = (state == S_REQ);
        rd_ext  = ext_q;
        rd_addr = {sec_q, {(SECTOR_OFF_W-4){1'b0}}, byte_q};
        busy    = (state != S_IDLE);
    end
endmodule

// File: rtl/bir_sector_scan_chk.sv
// Checker bound to the scanner: port-level protocol and result rules.
module bir_sector_scan_chk #(
    parameter int SECTOR_OFF_W = 15
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    start,
    input logic                    ext_enable,
    input logic                    prog_enable,
    input logic                    rd_req,
    input logic                    rd_ext,
    input logic [SECTOR_OFF_W-5:0] rec_addr_mid,
    input logic                    busy,
    input logic                    done,
    input logic                    found,
    input logic [1:0]              action
);
    a_r2_offset_in_record: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> rec_addr_mid == '0);
    a_r2_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> !rd_req);
    a_r6_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !rd_req);
    a_r9_ext_only_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_ext) |-> ext_enable);
    a_r10_miss_fallback: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !found) |-> (action == (prog_enable ? 2'd2 : 2'd3)));
    a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r11_results_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(found) && $stable(action)));
    a_r12_hit_boot: assert property (@(posedge clk) disable iff (!rst_n)
        (done && found) |-> action == 2'd1);
endmodule

bind bir_sector_scan bir_sector_scan_chk #(.SECTOR_OFF_W(SECTOR_OFF_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .ext_enable   (ext_enable),
    .prog_enable  (prog_enable),
    .rd_req       (rd_req),
    .rd_ext       (rd_ext),
    .rec_addr_mid (rd_addr[SECTOR_OFF_W-1:4]),
    .busy         (busy),
    .done         (done),
    .found        (found),
    .action       (action)
);

// File: tb/bir_sector_scan_tb.sv
module bir_sector_scan_tb;
    localparam int NS     = 16;
    localparam int OFF_W  = 15;
    localparam int SEC_W  = 4;
    localparam int ADDR_W = SEC_W + OFF_W;

    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic              rst_n, start, alt_magic_en, ext_enable, prog_enable;
    logic [15:0]       search_id;
    logic              rd_req, rd_ext, rd_valid, busy, done, found, found_ext;
    logic [ADDR_W-1:0] rd_addr;
    logic [7:0]        rd_data;
    logic [SEC_W-1:0]  found_sector;
    logic [3:0]        found_size;
    logic [1:0]        action;

    bir_sector_scan #(.NUM_SECTORS(NS), .SECTOR_OFF_W(OFF_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .search_id(search_id),
        .alt_magic_en(alt_magic_en), .ext_enable(ext_enable), .prog_enable(prog_enable),
        .rd_req(rd_req), .rd_ext(rd_ext), .rd_addr(rd_addr), .rd_valid(rd_valid),
        .rd_data(rd_data), .busy(busy), .done(done), .found(found), .found_ext(found_ext),
        .found_sector(found_sector), .found_size(found_size), .action(action)
    );

    // Memory model: one 16-byte record per sector, 0xFF elsewhere
    logic [7:0] int_mem [NS*16];
    logic [7:0] ext_mem [NS*16];
    int reads = 0;
    int bad_addr = 0;

    always @(posedge clk) begin
        rd_valid <= 1'b0;
        if (rst_n && rd_req) begin
            reads    <= reads + 1;
            rd_valid <= 1'b1;
            if (rd_addr[OFF_W-1:0] >= 16) begin
                bad_addr <= bad_addr + 1;
                rd_data  <= 8'hFF;
            end else if (rd_ext) begin
                rd_data <= ext_mem[int'(rd_addr[ADDR_W-1:OFF_W])*16 + int'(rd_addr[3:0])];
            end else begin
                rd_data <= int_mem[int'(rd_addr[ADDR_W-1:OFF_W])*16 + int'(rd_addr[3:0])];
            end
        end
    end

    int total = 0;
    int bad = 0;

    task automatic check(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < NS*16; i++) begin
            int_mem[i] = 8'hFF;
            ext_mem[i] = 8'hFF;
        end
    endtask

    // kind: 0 primary signature, 1 second signature, 2 corrupted signature
    task automatic put_rec(input bit ext, input int sec, input int kind,
                           input logic [7:0] cfg, input logic [7:0] st, input logic [15:0] id);
        logic [95:0] sig;
        logic [7:0]  b [16];
        sig = (kind == 1) ? 96'h123456782233445566778899 : 96'h123456781122334455667788;
        if (kind == 2) sig[7:0] = 8'h00;
        for (int k = 0; k < 12; k++) b[k] = sig[88-8*k +: 8];
        b[12] = cfg; b[13] = st; b[14] = id[15:8]; b[15] = id[7:0];
        for (int k = 0; k < 16; k++) begin
            if (ext) ext_mem[sec*16+k] = b[k];
            else     int_mem[sec*16+k] = b[k];
        end
    endtask

    int base;

    task automatic run_scan(input logic [15:0] sid, input bit alt, input bit ext, input bit prog);
        @(negedge clk);
        search_id = sid; alt_magic_en = alt; ext_enable = ext; prog_enable = prog;
        base  = reads;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done) @(negedge clk);
    endtask

    typedef struct packed {
        logic [1:0]  kind;
        logic [7:0]  status;
        logic [15:0] id;
        logic [15:0] sid;
        logic        alt;
        logic        hit;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 8'h01, 16'h0000, 16'h0000, 1'b0, 1'b1},  // R3 primary
        '{2'd1, 8'h01, 16'h0000, 16'h0000, 1'b1, 1'b1},  // R3 second, enabled
        '{2'd1, 8'h01, 16'h0000, 16'h0000, 1'b0, 1'b0},  // R3 second, disabled
        '{2'd2, 8'h01, 16'h0000, 16'h0000, 1'b1, 1'b0},  // R3 corrupted
        '{2'd0, 8'h00, 16'h0000, 16'h0000, 1'b0, 1'b0},  // R4 invalidated
        '{2'd0, 8'hFF, 16'h0000, 16'h0000, 1'b0, 1'b0},  // R4 erased
        '{2'd0, 8'h7E, 16'h0000, 16'h0000, 1'b0, 1'b1},  // R4 reserved value passes
        '{2'd0, 8'h01, 16'h1234, 16'h1234, 1'b0, 1'b1},  // R5 match
        '{2'd0, 8'h01, 16'h1234, 16'h3412, 1'b0, 1'b0}   // R5 byte order
    };

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; start = 1'b0; search_id = '0;
        alt_magic_en = 1'b0; ext_enable = 1'b0; prog_enable = 1'b1;
        clear_mem();
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "busy", int'(busy), 0);
        check("R1", "done", int'(done), 0);
        check("R1", "rd_req", int'(rd_req), 0);
        check("R1", "found", int'(found), 0);
        check("R1", "action", int'(action), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "busy after release", int'(busy), 0);

        // Table: single record at sector 2, internal only, programming fallback
        for (int v = 0; v < NV; v++) begin
            clear_mem();
            put_rec(1'b0, 2, int'(VECS[v].kind), 8'h00, VECS[v].status, VECS[v].id);
            run_scan(VECS[v].sid, VECS[v].alt, 1'b0, 1'b1);
            check("R3/R4/R5", "found", int'(found), int'(VECS[v].hit));
            check("R12/R10", "action", int'(action), VECS[v].hit ? 1 : 2);
            if (VECS[v].hit) check("R6", "sector", int'(found_sector), 2);
            check("R8/R6", "reads", reads - base, VECS[v].hit ? 48 : 256);
        end

        // R7: rejected good-signature record at 0 (size code 2) skips 1 and 2
        clear_mem();
        put_rec(1'b0, 0, 0, 8'h20, 8'h01, 16'h0001);
        put_rec(1'b0, 1, 0, 8'h00, 8'h01, 16'h0000);
        put_rec(1'b0, 3, 0, 8'h50, 8'h01, 16'h0000);
        run_scan(16'h0000, 1'b0, 1'b0, 1'b1);
        check("R7", "sector", int'(found_sector), 3);
        check("R7", "reads", reads - base, 32);
        check("R12", "size", int'(found_size), 5);
        @(negedge clk);
        check("R11", "done one cycle", int'(done), 0);
        repeat (3) @(negedge clk);
        check("R11", "found held", int'(found), 1);
        check("R11", "sector held", int'(found_sector), 3);

        // R6: two qualifying records, lowest wins
        clear_mem();
        put_rec(1'b0, 6, 0, 8'h00, 8'h01, 16'h0000);
        put_rec(1'b0, 4, 0, 8'h00, 8'h01, 16'h0000);
        run_scan(16'h0000, 1'b0, 1'b0, 1'b1);
        check("R6", "sector", int'(found_sector), 4);
        check("R6", "reads", reads - base, 80);

        // R9: image only in external memory
        clear_mem();
        put_rec(1'b1, 5, 0, 8'h10, 8'h01, 16'h0000);
        run_scan(16'h0000, 1'b0, 1'b1, 1'b1);
        check("R9", "found", int'(found), 1);
        check("R9", "found_ext", int'(found_ext), 1);
        check("R9", "sector", int'(found_sector), 5);
        check("R9", "reads", reads - base, 352);

        // R10: nothing anywhere, external enabled, programming allowed
        clear_mem();
        run_scan(16'h0000, 1'b0, 1'b1, 1'b1);
        check("R10", "action prog", int'(action), 2);
        check("R10", "reads", reads - base, 512);

        // R10: nothing, no external, programming disabled
        run_scan(16'h0000, 1'b0, 1'b0, 1'b0);
        check("R10", "action halt", int'(action), 3);
        check("R10", "found", int'(found), 0);

        // R7: oversized step at last sector ends the walk
        clear_mem();
        put_rec(1'b0, 15, 0, 8'hF0, 8'h00, 16'h0000);
        run_scan(16'h0000, 1'b0, 1'b0, 1'b1);
        check("R7", "past end found", int'(found), 0);
        check("R7", "past end reads", reads - base, 256);

        // R11: a start while busy is ignored
        clear_mem();
        put_rec(1'b0, 9, 0, 8'h00, 8'h01, 16'h0000);
        @(negedge clk);
        search_id = 16'h0000; alt_magic_en = 1'b0; ext_enable = 1'b0; prog_enable = 1'b1;
        base = reads;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (100) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done) @(negedge clk);
        check("R11", "restart ignored sector", int'(found_sector), 9);
        check("R11", "restart ignored reads", reads - base, 160);

        check("R2", "out-of-record reads", bad_addr, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule